// File: doc/BRIEF.md
# Descriptor Chain Fetcher

This block feeds a multi-source data engine with work. Software gives it the address of a first descriptor and pulses a start input. Each descriptor is a fixed record of eight 32-bit words in local memory, aligned on a 32-byte boundary. The fetcher reads a record one word at a time over a simple request/response read port. It places every word in its own register and then offers the complete set to the engine with a valid signal.

When the engine signals that the transfer is finished, the fetcher follows the record's link word to the next record. A link that is zero after alignment ends the chain. The fetcher then reports completion with a one-cycle pulse and goes idle.

Status consists of a busy flag and a count of completed descriptors. A synchronous abort input returns the fetcher to idle from any state.

Top module: `dchain_fetch`

## Requirements
- R1: After reset the block is idle: `busy_o`, `desc_valid_o`, `rd_req_o` and `chain_done_o` are 0 and `desc_cnt_o` is 0.
- R2: A descriptor is fetched as eight single-cycle read requests at base+0, base+4, and so on up to base+28, in that order. Each request waits for the `rd_rvalid_i` answer to the previous one, and a response is taken no earlier than the cycle after its request.
- R3: Word k of a record (byte offset 4k) lands in a fixed register: k=0 link (`next_ptr_o`), k=1..4 sources 1..4 (`src_addr_o` bits [32(k-1)+31:32(k-1)]), k=5 `dst_addr_o`, k=6 `byte_count_o`, k=7 `ctrl_o`.
- R4: Bits 4:0 of `start_addr_i` are ignored; the first record is read from the address with those bits cleared.
- R5: Once the eighth word is loaded, `desc_valid_o` stays high and every descriptor output stays unchanged, with no read request, until `engine_done_i` (or abort).
- R6: When `engine_done_i` is seen and the link with bits 4:0 cleared is non-zero, the next record is fetched from that cleared address.
- R7: When `engine_done_i` is seen and the link with bits 4:0 cleared is zero, `chain_done_o` pulses high for exactly one cycle, `busy_o` is low in that same cycle, and no further reads are made.
- R8: `busy_o` is high from the cycle after an accepted start until the chain ends or is aborted.
- R9: A start pulse while busy has no effect: the address sequence and the descriptor count continue unchanged.
- R10: `desc_cnt_o` is cleared by an accepted start and increases by one for each `engine_done_i` taken while `desc_valid_o` is high.
- R11: `abort_i` makes the block idle in the next cycle from any state. `busy_o` and `desc_valid_o` are then low and no `chain_done_o` pulse occurs. When abort and `engine_done_i` fall in the same cycle, abort wins and `desc_cnt_o` does not increase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken when idle |
| start_addr_i | input | ADDR_W | Address of the first record |
| abort_i | input | 1 | Synchronous abort |
| rd_req_o | output | 1 | Single-cycle read request |
| rd_addr_o | output | ADDR_W | Byte address of the word requested |
| rd_rvalid_i | input | 1 | Read response valid |
| rd_rdata_i | input | DATA_W | Read response data |
| desc_valid_o | output | 1 | Loaded descriptor offered to the engine |
| engine_done_i | input | 1 | Engine has finished the offered descriptor |
| next_ptr_o | output | DATA_W | Link word |
| src_addr_o | output | 4*ADDR_W | Sources 1..4, source 1 in the low slice |
| dst_addr_o | output | ADDR_W | Destination address |
| byte_count_o | output | DATA_W | Byte count word |
| ctrl_o | output | DATA_W | Control word |
| busy_o | output | 1 | Chain in progress |
| chain_done_o | output | 1 | One-cycle pulse at the end of a chain |
| desc_cnt_o | output | CNT_W | Completed descriptors in the current chain |

## Verification
Two functions can fall in the same cycle: the engine's completion of the last descriptor, and an abort. The bench's engine model drives `engine_done_i` and `abort_i` together on the same clock edge while a final descriptor is offered. It then expects no completion pulse and a descriptor count that stays at zero. A second collision is a start pulse that arrives mid-chain. The scoreboard judges it by the unchanged read address sequence and by the final count.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
   localparam int unsigned DESC_WORDS = 8;
   localparam int unsigned IDX_W      = $clog2(DESC_WORDS);

   typedef enum logic [IDX_W-1:0] {
      SLOT_NEXT  = 3'd0,
      SLOT_SRC1  = 3'd1,
      SLOT_SRC2  = 3'd2,
      SLOT_SRC3  = 3'd3,
      SLOT_SRC4  = 3'd4,
      SLOT_DST   = 3'd5,
      SLOT_COUNT = 3'd6,
      SLOT_CTRL  = 3'd7
   } slot_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_WAIT,
      ST_HOLD
   } fetch_st_e;
endpackage

// File: rtl/dchain_regs.sv
module dchain_regs
   import dchain_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter bit          SLOT_RESET = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en_i,
   input  logic [IDX_W-1:0]             wr_idx_i,
   input  logic [DATA_W-1:0]            wr_data_i,
   output logic [DESC_WORDS*DATA_W-1:0] words_o
);
   // one register per descriptor word, written only when addressed
   for (genvar g = 0; g < DESC_WORDS; g++) begin : g_slot
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));
      if (SLOT_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_data_i;
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (hit) q <= wr_data_i;
         end
      end
      assign words_o[g*DATA_W +: DATA_W] = q;
   end
endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
   import dchain_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              abort_i,
   input  logic              rd_rvalid_i,
   input  logic              engine_done_i,
   input  logic [ADDR_W-1:0] next_ptr_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic              desc_valid_o,
   output logic              busy_o,
   output logic              chain_done_o,
   output logic [CNT_W-1:0]  desc_cnt_o
);
   localparam int unsigned BYTES_PER_WORD = DATA_W / 8;
   localparam int unsigned OFS_LSB        = $clog2(BYTES_PER_WORD);
   localparam int unsigned ALIGN_LSB      = $clog2(DESC_WORDS * BYTES_PER_WORD);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_LSB) - ADDR_W'(1));

   fetch_st_e         state;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] base;
   logic [CNT_W-1:0]  cnt;
   logic              done_q;
   logic [ADDR_W-1:0] link_addr;
   logic              link_end;
   logic              last_word;

   assign link_addr = next_ptr_i & ALIGN_MASK;
   assign link_end  = (link_addr == '0);
   assign last_word = (idx == IDX_W'(DESC_WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         base   <= '0;
         cnt    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort_i) begin
            state <= ST_IDLE;
         end else begin
            unique case (state)
               ST_IDLE: if (start_i) begin
                  state <= ST_REQ;
                  base  <= start_addr_i & ALIGN_MASK;
                  idx   <= '0;
                  cnt   <= '0;
               end
               ST_REQ:  state <= ST_WAIT;
               ST_WAIT: if (rd_rvalid_i) begin
                  if (last_word) state <= ST_HOLD;
                  else begin
                     idx   <= idx + IDX_W'(1);
                     state <= ST_REQ;
                  end
               end
               ST_HOLD: if (engine_done_i) begin
                  cnt <= cnt + CNT_W'(1);
                  idx <= '0;
                  if (link_end) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     base  <= link_addr;
                     state <= ST_REQ;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign rd_req_o     = (state == ST_REQ);
   assign rd_addr_o    = base | (ADDR_W'(idx) << OFS_LSB);
   assign wr_en_o      = (state == ST_WAIT) && rd_rvalid_i && !abort_i;
   assign wr_idx_o     = idx;
   assign desc_valid_o = (state == ST_HOLD);
   assign busy_o       = (state != ST_IDLE);
   assign chain_done_o = done_q;
   assign desc_cnt_o   = cnt;

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o); // R2
   AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid_o && !engine_done_i && !abort_i) |=> desc_valid_o); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      chain_done_o |=> !chain_done_o); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      chain_done_o |-> !busy_o); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !abort_i && !(desc_valid_o && engine_done_i))
      |=> (desc_cnt_o == $past(desc_cnt_o))); // R9
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid_o && engine_done_i && !abort_i)
      |=> (desc_cnt_o == $past(desc_cnt_o) + CNT_W'(1))); // R10
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!busy_o && !desc_valid_o && !chain_done_o)); // R11
endmodule

// File: rtl/dchain_fetch.sv
module dchain_fetch
   import dchain_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_W      = 16,
   parameter bit          SLOT_RESET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [ADDR_W-1:0]   start_addr_i,
   input  logic                abort_i,
   output logic                rd_req_o,
   output logic [ADDR_W-1:0]   rd_addr_o,
   input  logic                rd_rvalid_i,
   input  logic [DATA_W-1:0]   rd_rdata_i,
   output logic                desc_valid_o,
   input  logic                engine_done_i,
   output logic [DATA_W-1:0]   next_ptr_o,
   output logic [4*ADDR_W-1:0] src_addr_o,
   output logic [ADDR_W-1:0]   dst_addr_o,
   output logic [DATA_W-1:0]   byte_count_o,
   output logic [DATA_W-1:0]   ctrl_o,
   output logic                busy_o,
   output logic                chain_done_o,
   output logic [CNT_W-1:0]    desc_cnt_o
);
   localparam int unsigned BYTES_PER_WORD = DATA_W / 8;
   localparam int unsigned ALIGN_LSB      = $clog2(DESC_WORDS * BYTES_PER_WORD);
   localparam int unsigned NUM_SRC        = 4;

   if ((DATA_W % 8) != 0 || (1 << $clog2(BYTES_PER_WORD)) != BYTES_PER_WORD) begin : g_bad_data
      $error("dchain_fetch: DATA_W must be a power-of-two number of bytes");
   end
   if (ADDR_W > DATA_W || ADDR_W <= ALIGN_LSB) begin : g_bad_addr
      $error("dchain_fetch: ADDR_W must fit a word and exceed the alignment bits");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("dchain_fetch: CNT_W must be at least 1");
   end

   logic [DESC_WORDS*DATA_W-1:0] words;
   logic                         wr_en;
   logic [IDX_W-1:0]             wr_idx;

   dchain_regs #(
      .DATA_W     (DATA_W),
      .SLOT_RESET (SLOT_RESET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (rd_rdata_i),
      .words_o   (words)
   );

   dchain_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .start_addr_i  (start_addr_i),
      .abort_i       (abort_i),
      .rd_rvalid_i   (rd_rvalid_i),
      .engine_done_i (engine_done_i),
      .next_ptr_i    (next_ptr_o[ADDR_W-1:0]),
      .rd_req_o      (rd_req_o),
      .rd_addr_o     (rd_addr_o),
      .wr_en_o       (wr_en),
      .wr_idx_o      (wr_idx),
      .desc_valid_o  (desc_valid_o),
      .busy_o        (busy_o),
      .chain_done_o  (chain_done_o),
      .desc_cnt_o    (desc_cnt_o)
   );

   assign next_ptr_o   = words[int'(SLOT_NEXT)*DATA_W +: DATA_W];
   assign dst_addr_o   = words[int'(SLOT_DST)*DATA_W +: ADDR_W];
   assign byte_count_o = words[int'(SLOT_COUNT)*DATA_W +: DATA_W];
   assign ctrl_o       = words[int'(SLOT_CTRL)*DATA_W +: DATA_W];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign src_addr_o[s*ADDR_W +: ADDR_W] = words[(int'(SLOT_SRC1) + s)*DATA_W +: ADDR_W];
   end

   AST_REGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid_o && !engine_done_i && !abort_i) |=> $stable(words)); // R5
   AST_NO_LOAD_WHILE_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid_o |-> !wr_en); // R5
endmodule

// File: tb/dchain_fetch_bench.sv
module dchain_fetch_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [31:0]  start_addr_i = '0;
   logic         abort_drv = 1'b0;
   logic         eng_abort = 1'b0;
   logic         abort_i;
   logic         rd_req_o;
   logic [31:0]  rd_addr_o;
   logic         rd_rvalid_i = 1'b0;
   logic [31:0]  rd_rdata_i = '0;
   logic         desc_valid_o;
   logic         engine_done_i = 1'b0;
   logic [31:0]  next_ptr_o;
   logic [127:0] src_addr_o;
   logic [31:0]  dst_addr_o;
   logic [31:0]  byte_count_o;
   logic [31:0]  ctrl_o;
   logic         busy_o;
   logic         chain_done_o;
   logic [15:0]  desc_cnt_o;

   assign abort_i = abort_drv | eng_abort;

   always #5 clk = ~clk;

   dchain_fetch u_dchain_fetch (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .abort_i(abort_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_rvalid_i(rd_rvalid_i), .rd_rdata_i(rd_rdata_i),
      .desc_valid_o(desc_valid_o), .engine_done_i(engine_done_i),
      .next_ptr_o(next_ptr_o), .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
      .byte_count_o(byte_count_o), .ctrl_o(ctrl_o), .busy_o(busy_o),
      .chain_done_o(chain_done_o), .desc_cnt_o(desc_cnt_o)
   );

   logic [31:0]  mem [int unsigned];
   int unsigned  exp_addr_q [$];
   logic [255:0] exp_desc_q [$];
   int n_chk = 0;
   int n_fail = 0;
   int lat = 1;
   int eng_delay = 2;
   bit abort_on_done = 1'b0;
   int done_pulses = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic logic [255:0] port_words();
      return {ctrl_o, byte_count_o, dst_addr_o, src_addr_o, next_ptr_o};
   endfunction

   // driver: writes records and pushes expected reads and expected register sets
   task automatic build_chain(input logic [31:0] first_base, input int n,
                              input logic [31:0] stride, input logic [31:0] last_link,
                              input logic [7:0] tag);
      for (int d = 0; d < n; d++) begin
         logic [31:0]  b;
         logic [255:0] rec;
         b = first_base + 32'(d) * stride;
         for (int k = 0; k < 8; k++) begin
            logic [31:0] w;
            if (k == 0) w = (d == n - 1) ? last_link : ((b + stride) | 32'h0000_000B);
            else        w = {tag, 8'(d), 8'(k), 8'h5A ^ 8'(k * 17)};
            mem[b + 32'(4 * k)] = w;
            exp_addr_q.push_back(b + 32'(4 * k));
            rec[k*32 +: 32] = w;
         end
         exp_desc_q.push_back(rec);
      end
   endtask

   // memory model and read-address monitor
   initial begin
      @(negedge clk);
      forever begin
         if (rst_n && rd_req_o) begin
            logic [31:0] a;
            a = rd_addr_o;
            if (exp_addr_q.size() == 0) begin
               check(1'b0, "R2 R7", "unexpected read", longint'(a), 0);
            end else begin
               int unsigned e;
               e = exp_addr_q.pop_front();
               check(a == e, "R2 R4 R6 R9", "read address", longint'(a), longint'(e));
            end
            repeat (lat) @(negedge clk);
            rd_rvalid_i = 1'b1;
            rd_rdata_i  = mem.exists(a) ? mem[a] : 32'hDEAD_BEEF;
            @(negedge clk);
            rd_rvalid_i = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   // engine model and descriptor scoreboard
   initial begin
      @(negedge clk);
      forever begin
         if (rst_n && desc_valid_o) begin
            logic [255:0] got, exp, snap;
            bit stable_ok;
            got = port_words();
            if (exp_desc_q.size() == 0) begin
               check(1'b0, "R3", "unexpected descriptor", longint'(got[31:0]), 0);
            end else begin
               exp = exp_desc_q.pop_front();
               for (int k = 0; k < 8; k++) begin
                  if (got[k*32 +: 32] != exp[k*32 +: 32])
                     $display("  word %0d mismatch", k);
               end
               check(got == exp, "R3", "descriptor word0", longint'(got[31:0]), longint'(exp[31:0]));
            end
            snap = got;
            stable_ok = 1'b1;
            repeat (eng_delay) begin
               @(negedge clk);
               if (port_words() != snap || rd_req_o || !desc_valid_o) stable_ok = 1'b0;
            end
            check(stable_ok, "R5", "hold while offered", longint'(stable_ok), 1);
            engine_done_i = 1'b1;
            if (abort_on_done) eng_abort = 1'b1;
            @(negedge clk);
            engine_done_i = 1'b0;
            eng_abort = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && chain_done_o) done_pulses++;
      end
   end

   task automatic pulse_start(input logic [31:0] a);
      start_addr_i = a;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // waits for the end-of-chain pulse; busy must stay high up to it
   task automatic wait_done(output bit found);
      bit busy_ok;
      found = 1'b0;
      busy_ok = 1'b1;
      for (int i = 0; i < 4000 && !found; i++) begin
         if (chain_done_o) found = 1'b1;
         else begin
            if (!busy_o) busy_ok = 1'b0;
            @(negedge clk);
         end
      end
      check(found, "R7", "chain_done seen", longint'(found), 1);
      check(busy_ok, "R8", "busy held until end", longint'(busy_ok), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", "run hung", 0, 1);
      summary();
      $finish;
   end

   initial begin
      bit found;
      int p0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy_o, "R1", "busy", longint'(busy_o), 0);
      check(!desc_valid_o, "R1", "desc_valid", longint'(desc_valid_o), 0);
      check(!rd_req_o, "R1", "rd_req", longint'(rd_req_o), 0);
      check(!chain_done_o, "R1", "chain_done", longint'(chain_done_o), 0);
      check(desc_cnt_o == 0, "R1", "count", longint'(desc_cnt_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // three linked records, unaligned start (R4), junk link bits (R6),
      // last link 0x13 clears to zero (R7); a stray start mid-chain (R9)
      lat = 1; eng_delay = 3;
      build_chain(32'h0001_0000, 3, 32'h0000_0100, 32'h0000_0013, 8'hA1);
      pulse_start(32'h0001_0017);
      check(busy_o, "R8", "busy after start", longint'(busy_o), 1);
      repeat (30) @(negedge clk);
      pulse_start(32'h0005_0000);
      wait_done(found);
      check(!busy_o, "R7", "busy low with pulse", longint'(busy_o), 0);
      check(desc_cnt_o == 3, "R10 R9", "count at end", longint'(desc_cnt_o), 3);
      @(negedge clk);
      check(!chain_done_o, "R7", "pulse one cycle", longint'(chain_done_o), 0);
      repeat (20) @(negedge clk);
      check(exp_addr_q.size() == 0, "R2", "all reads made", longint'(exp_addr_q.size()), 0);
      check(exp_desc_q.size() == 0, "R3", "all records offered", longint'(exp_desc_q.size()), 0);
      check(done_pulses == 1, "R7", "pulse count", longint'(done_pulses), 1);

      // single record, slower memory, immediate engine, link 0x1F ends chain
      lat = 3; eng_delay = 0;
      build_chain(32'h0002_0040, 1, 32'h0000_0040, 32'h0000_001F, 8'hB2);
      pulse_start(32'h0002_0040);
      wait_done(found);
      check(desc_cnt_o == 1, "R10", "count single", longint'(desc_cnt_o), 1);
      repeat (10) @(negedge clk);

      // abort in the middle of a fetch
      lat = 2; eng_delay = 1;
      p0 = done_pulses;
      build_chain(32'h0003_0000, 2, 32'h0000_0020, 32'h0000_0000, 8'hC3);
      pulse_start(32'h0003_0000);
      repeat (9) @(negedge clk);
      abort_drv = 1'b1;
      exp_addr_q.delete();
      exp_desc_q.delete();
      @(negedge clk);
      abort_drv = 1'b0;
      check(!busy_o, "R11", "busy after abort", longint'(busy_o), 0);
      check(!desc_valid_o, "R11", "valid after abort", longint'(desc_valid_o), 0);
      repeat (20) @(negedge clk);
      check(done_pulses == p0, "R11", "no pulse on abort", longint'(done_pulses), longint'(p0));

      // abort and engine_done in the same cycle on the last record
      lat = 1; eng_delay = 2; abort_on_done = 1'b1;
      p0 = done_pulses;
      build_chain(32'h0004_0000, 1, 32'h0000_0020, 32'h0000_0000, 8'hD4);
      pulse_start(32'h0004_0000);
      repeat (60) @(negedge clk);
      abort_on_done = 1'b0;
      check(!busy_o, "R11", "idle after collision", longint'(busy_o), 0);
      check(done_pulses == p0, "R11", "no pulse on collision", longint'(done_pulses), longint'(p0));
      check(desc_cnt_o == 0, "R11", "count not bumped", longint'(desc_cnt_o), 0);

      // recovery: a fresh chain clears and counts again
      lat = 1; eng_delay = 1;
      build_chain(32'h0006_0000, 2, 32'h0000_0400, 32'h0000_0000, 8'hE5);
      pulse_start(32'h0006_0000);
      wait_done(found);
      check(desc_cnt_o == 2, "R10", "count after restart", longint'(desc_cnt_o), 2);
      repeat (10) @(negedge clk);
      check(exp_addr_q.size() == 0, "R6", "link followed", longint'(exp_addr_q.size()), 0);

      summary();
      $finish;
   end
endmodule